// File: doc/BRIEF.md
# Multi-Channel Streaming CRC-32 Checker

The block checks CRC-32 codewords arriving on a 4-byte streaming interface on which packets of several independent channels are interleaved. Every beat names the channel it belongs to. The block keeps one running CRC per channel in a small context memory. Consecutive beats may therefore come from any channel in any order, including a new channel on every cycle, with no switching penalty.

When a packet's last beat has been consumed, the block reports a one-cycle result strobe, a bad-codeword flag and the channel of that packet. The report comes a fixed two cycles after that beat.

After an active-low reset, the block writes a known value into every channel context, one entry per cycle. It then raises `in_ready`. Back-pressure rules: a beat is consumed only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low for the whole initialization sweep, stays high from then until the next reset, and never drops once raised. The result side has no ready signal, so the consumer must take every result strobe in the cycle it appears.

Top module: `crc_mc_checker`

## Requirements
- R1: The CRC is the reflected CRC-32 (polynomial 0x04C11DB7, shift register preset to 0xFFFFFFFF). A packet is good when the register, after all its bytes including the 4 appended check bytes, holds the residue 0xC704DD7B in MSB-first form (0xDEBB20E3 in the right-shifting register). For a good packet `out_bad` is 0 while `out_valid` is 1.
- R2: For a packet whose codeword does not check, `out_bad` is 1 in the same cycle as `out_valid`. `out_bad` is 0 whenever `out_valid` is 0.
- R3: `out_channel` equals the `in_channel` of the packet's last beat, in the cycle where `out_valid` is 1.
- R4: Each channel has its own context. Beats of different channels may alternate on every cycle or be separated by idle cycles, and each packet's result is unaffected by other channels' traffic.
- R5: Consecutive beats of the same channel on back-to-back cycles give the same result as any other ordering.
- R6: `out_valid` is high for exactly one cycle per packet. That cycle is the second cycle after the cycle in which the end-of-packet beat is consumed. No result appears without such a beat.
- R7: Byte lane k is `in_data[8k+7:8k]`, and lane 0 is the first byte in stream order. On the end-of-packet beat, `in_empty` gives the number of unused lanes, counted from lane 3 downwards. On other beats `in_empty` is ignored and all 4 lanes count.
- R8: A start-of-packet beat begins from the preset value, whatever the channel's context holds. The leftover state of a packet that never ended does not affect the next packet on that channel.
- R9: While `rst_n` is low and for the first CHANNELS cycles after it rises, `in_ready` is 0. It becomes 1 after exactly CHANNELS clock edges and then stays 1. Beats offered while `in_ready` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Block accepts beats (initialization complete) |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | 2 | Unused trailing lanes on the last beat |
| in_channel | input | $clog2(CHANNELS) | Channel the beat belongs to |
| in_data | input | 32 | Four byte lanes, lane 0 first |
| out_valid | output | 1 | One-cycle result strobe |
| out_bad | output | 1 | Codeword failed the check |
| out_channel | output | $clog2(CHANNELS) | Channel the result belongs to |

## Verification
The hardest case to reach is a beat whose channel context was rewritten on the very edge at which its own read was captured. This happens only when a channel appears on two consecutive cycles. The bench reaches it by draining each channel's multi-beat packet without gaps. It also alternates channels every cycle with and without idle slots, so that the same-channel and different-channel read paths both carry real results. A packet abandoned mid-stream and then restarted on the same channel shows that stale context is discarded.

// File: rtl/crc_mc_pkg.sv
`timescale 1ns/1ps
package crc_mc_pkg;
  localparam logic [31:0] CRC_PRESET  = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_RV = 32'hEDB8_8320;
  localparam logic [31:0] CRC_GOOD    = 32'hDEBB_20E3;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY_RV) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/crc_mc_init.sv
`timescale 1ns/1ps
module crc_mc_init #(
  parameter int CHANNELS = 4,
  localparam int CW = $clog2(CHANNELS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          busy,
  output logic [CW-1:0] idx,
  output logic          done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      idx <= idx + 1'b1;
      if (idx == CW'(CHANNELS - 1)) done <= 1'b1;
    end
  end
  assign busy = !done;
endmodule

// File: rtl/crc_mc_ctx_ram.sv
`timescale 1ns/1ps
module crc_mc_ctx_ram #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  // read returns the pre-write content when both ports hit one entry
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/crc_mc_step.sv
`timescale 1ns/1ps
module crc_mc_step #(
  parameter int LANES = 4,
  localparam int DW   = 8 * LANES,
  localparam int NB_W = $clog2(LANES + 1)
) (
  input  logic [31:0]   crc_in,
  input  logic [DW-1:0] data,
  input  logic [NB_W-1:0] nbytes,
  output logic [31:0]   crc_out
);
  import crc_mc_pkg::*;
  logic [LANES:0][31:0] chain;
  assign chain[0] = crc_in;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [31:0] upd;
    assign upd = crc_byte(chain[i], data[8*i +: 8]);
    assign chain[i+1] = (NB_W'(i) < nbytes) ? upd : chain[i];
  end
  assign crc_out = chain[LANES];
endmodule

// File: rtl/crc_mc_checker.sv
`timescale 1ns/1ps
module crc_mc_checker #(
  parameter int CHANNELS = 4,
  parameter int LANES    = 4,
  localparam int CW   = $clog2(CHANNELS),
  localparam int EW   = $clog2(LANES),
  localparam int DW   = 8 * LANES,
  localparam int NB_W = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [EW-1:0] in_empty,
  input  logic [CW-1:0] in_channel,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_bad,
  output logic [CW-1:0] out_channel
);
  import crc_mc_pkg::*;

  // initialization sweep
  logic          init_busy;
  logic [CW-1:0] init_idx;
  logic          init_done;

  crc_mc_init #(.CHANNELS(CHANNELS)) u_init (
    .clk(clk), .rst_n(rst_n), .busy(init_busy), .idx(init_idx), .done(init_done)
  );

  assign in_ready = init_done;

  logic accept;
  assign accept = in_valid && in_ready;

  // stage A: beat registered alongside the context read
  logic            a_vld, a_sop, a_eop;
  logic [CW-1:0]   a_ch;
  logic [NB_W-1:0] a_nb;
  logic [DW-1:0]   a_data;
  logic [NB_W-1:0] in_nb;

  assign in_nb = in_eop ? (NB_W'(LANES) - NB_W'(in_empty)) : NB_W'(LANES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld <= 1'b0;
      a_sop <= 1'b0;
      a_eop <= 1'b0;
      a_ch  <= '0;
      a_nb  <= '0;
    end else begin
      a_vld <= accept;
      a_sop <= in_sop;
      a_eop <= in_eop;
      a_ch  <= in_channel;
      a_nb  <= in_nb;
    end
  end

  always_ff @(posedge clk) a_data <= in_data;

  // context memory
  logic          ram_we;
  logic [CW-1:0] ram_waddr;
  logic [31:0]   ram_wdata;
  logic [31:0]   ram_q;
  logic [31:0]   crc_next;

  always_comb begin
    if (init_busy) begin
      ram_we    = 1'b1;
      ram_waddr = init_idx;
      ram_wdata = CRC_PRESET;
    end else begin
      ram_we    = a_vld;
      ram_waddr = a_ch;
      ram_wdata = crc_next;
    end
  end

  crc_mc_ctx_ram #(.DEPTH(CHANNELS), .WIDTH(32)) u_ctx (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(in_channel), .rdata(ram_q)
  );

  // last write, kept to cover a read captured at the same edge
  logic          w_vld;
  logic [CW-1:0] w_ch;
  logic [31:0]   w_crc;
  logic [31:0]   crc_base;

  always_comb begin
    if (a_sop)                     crc_base = CRC_PRESET;
    else if (w_vld && w_ch == a_ch) crc_base = w_crc;
    else                           crc_base = ram_q;
  end

  crc_mc_step #(.LANES(LANES)) u_step (
    .crc_in(crc_base), .data(a_data), .nbytes(a_nb), .crc_out(crc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_vld <= 1'b0;
      w_ch  <= '0;
      w_crc <= '0;
    end else begin
      w_vld <= a_vld;
      w_ch  <= a_ch;
      w_crc <= crc_next;
    end
  end

  // result stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_bad     <= 1'b0;
      out_channel <= '0;
    end else begin
      out_valid   <= a_vld && a_eop;
      out_bad     <= a_vld && a_eop && (crc_next != CRC_GOOD);
      out_channel <= a_ch;
    end
  end
endmodule

// File: rtl/crc_mc_checker_props.sv
`timescale 1ns/1ps
module crc_mc_checker_props #(
  parameter int CHANNELS = 4,
  localparam int CW = $clog2(CHANNELS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_eop,
  input logic [CW-1:0] in_channel,
  input logic          out_valid,
  input logic          out_bad,
  input logic [CW-1:0] out_channel
);
  a_r2_bad_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_bad |-> out_valid);

  a_r3_channel_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_channel == $past(in_channel, 2));

  a_r6_result_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eop) |-> ##2 out_valid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready && in_eop, 2));

  a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  a_r9_nothing_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_ready, 2));
endmodule

bind crc_mc_checker crc_mc_checker_props #(.CHANNELS(CHANNELS)) u_props (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_eop(in_eop), .in_channel(in_channel), .out_valid(out_valid),
  .out_bad(out_bad), .out_channel(out_channel)
);

// File: tb/crc_mc_checker_test.sv
`timescale 1ns/1ps
module crc_mc_checker_test;
  localparam int CH = 4;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [1:0]    in_empty = '0;
  logic [CW-1:0] in_channel = '0;
  logic [31:0]   in_data = '0;
  logic          in_ready, out_valid, out_bad;
  logic [CW-1:0] out_channel;

  always #2 clk = ~clk;

  crc_mc_checker #(.CHANNELS(CH), .LANES(4)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
    .in_channel(in_channel), .in_data(in_data), .out_valid(out_valid),
    .out_bad(out_bad), .out_channel(out_channel)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // packet store per channel
  logic [7:0] pkt [CH][64];
  int plen [CH], ppos [CH];
  bit pbad [CH];

  // expected and observed results
  int exp_ch [64], exp_cyc [64], got_ch [64], got_cyc [64];
  bit exp_bad [64], got_bad [64];
  int ne = 0, ng = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid && ng < 64) begin
      got_ch[ng] = int'(out_channel);
      got_bad[ng] = out_bad;
      got_cyc[ng] = cyc;
      ng = ng + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic build(input int ch, input int paylen, input int seed, input bit corrupt);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < paylen; i++) begin
      pkt[ch][i] = 8'((ch * 37) + (i * 13) + seed);
      c = ref_crc(c, pkt[ch][i]);
    end
    c = ~c;
    for (int i = 0; i < 4; i++) pkt[ch][paylen + i] = c[8*i +: 8];
    if (corrupt) pkt[ch][0] = pkt[ch][0] ^ 8'h10;
    plen[ch] = paylen + 4;
    ppos[ch] = 0;
    pbad[ch] = corrupt;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic send_beat(input int ch);
    int nb;
    nb = plen[ch] - ppos[ch];
    if (nb > 4) nb = 4;
    @(negedge clk);
    in_valid = 1'b1;
    in_channel = CW'(ch);
    in_sop = (ppos[ch] == 0);
    in_eop = (ppos[ch] + nb == plen[ch]);
    in_empty = in_eop ? 2'(4 - nb) : 2'b11;   // R7: junk on non-final beats
    for (int i = 0; i < 4; i++)
      in_data[8*i +: 8] = (i < nb) ? pkt[ch][ppos[ch] + i] : 8'hA5;
    ppos[ch] += nb;
    if (in_eop) begin
      exp_ch[ne] = ch;
      exp_bad[ne] = pbad[ch];
      exp_cyc[ne] = cyc + 2;
      ne++;
    end
  endtask

  // mode 0: round robin every cycle, 1: drain each channel, 2: round robin with gaps
  task automatic play(input int mode);
    int rr = 0;
    while (1) begin
      int pick = -1;
      for (int k = 0; k < CH; k++) begin
        int c = (mode == 1) ? k : (rr + k) % CH;
        if (pick < 0 && ppos[c] < plen[c]) pick = c;
      end
      if (pick < 0) break;
      rr = pick + 1;
      send_beat(pick);
      if (mode == 2) idle(1);
    end
    idle(1);
  endtask

  task automatic clear_all();
    for (int c = 0; c < CH; c++) begin plen[c] = 0; ppos[c] = 0; end
    ne = 0;
    ng = 0;
  endtask

  task automatic verify(input string req);
    idle(4);
    chk(ng == ne, {req, " result count"}, ng, ne);
    for (int i = 0; i < ne && i < ng; i++) begin
      chk(got_ch[i] == exp_ch[i], {req, " R3 channel"}, got_ch[i], exp_ch[i]);
      chk(got_bad[i] == exp_bad[i], {req, " R1/R2 bad flag"}, got_bad[i], exp_bad[i]);
      chk(got_cyc[i] == exp_cyc[i], {req, " R6 latency"}, got_cyc[i], exp_cyc[i]);
    end
  endtask

  task automatic t_reset();
    int n = 0;
    clear_all();
    rst_n = 1'b0;
    in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_empty = '0;
    in_channel = '0; in_data = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b0, "R9 ready low in reset", in_ready, 0);
    chk(out_valid == 1'b0, "R6 no result in reset", out_valid, 0);
    rst_n = 1'b1;
    while (n < 50) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (in_ready) break;
    end
    chk(n == CH, "R9 init cycles", n, CH);
    in_valid = 1'b0;
    idle(4);
    chk(ng == 0, "R9 beats before ready ignored", ng, 0);
    chk(in_ready == 1'b1, "R9 ready stays high", in_ready, 1);
  endtask

  task automatic t_single_empties();
    clear_all();
    for (int e = 0; e < 4; e++) begin
      build(2, 12 + e, 5 * e, 1'b0);   // totals 16..19 bytes: empty 0,3,2,1
      play(1);
    end
    verify("R1 R7 single channel");
  endtask

  task automatic t_bad();
    clear_all();
    build(1, 10, 3, 1'b1);
    build(3, 11, 9, 1'b0);
    build(0, 6, 1, 1'b1);
    play(0);
    verify("R2 corrupted");
  endtask

  task automatic t_interleave();
    clear_all();
    build(0, 9, 2, 1'b0);
    build(1, 22, 4, 1'b0);
    build(2, 5, 6, 1'b0);
    build(3, 31, 8, 1'b0);
    play(0);
    verify("R4 interleave");
  endtask

  task automatic t_back_to_back();
    clear_all();
    build(0, 17, 11, 1'b0);
    build(1, 24, 12, 1'b1);
    build(2, 33, 13, 1'b0);
    build(3, 8, 14, 1'b0);
    play(1);
    verify("R5 same channel back to back");
  endtask

  task automatic t_gaps();
    clear_all();
    build(0, 14, 21, 1'b0);
    build(2, 15, 22, 1'b0);
    build(3, 7, 23, 1'b1);
    play(2);
    verify("R4 with idle gaps");
  endtask

  task automatic t_abort();
    clear_all();
    build(1, 30, 40, 1'b0);
    for (int i = 0; i < 3; i++) send_beat(1);   // no end-of-packet
    build(1, 7, 41, 1'b0);
    build(2, 12, 42, 1'b0);
    play(0);
    verify("R8 aborted packet");
  endtask

  task automatic t_minimal();
    clear_all();
    build(0, 0, 0, 1'b0);    // check bytes only, one beat
    build(3, 1, 50, 1'b0);   // 5 bytes, last beat empty 3
    play(0);
    verify("R1 R7 minimal packets");
  endtask

  initial begin
    t_reset();
    t_single_empties();
    t_bad();
    t_interleave();
    t_back_to_back();
    t_gaps();
    t_abort();
    t_minimal();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule